// File: doc/BRIEF.md
# Register-Driven Two-Wire Bus Byte Master

This block is a master for a two-wire serial bus of the I2C kind. Software runs it through four byte-wide registers. It first loads a word-address byte and a data byte. It then writes the target's 7-bit address and a read/write flag into the launch register, and that write starts exactly one single-byte transfer on the bus. A control/status register picks one of two addressing styles. In the default style a word-address byte follows the target address. In the short style the data phase comes directly after the address. The same register reports a busy flag, a sticky no-acknowledge error, the state of an external configuration-download engine and whether a memory was present at reset.

The clock line is divided down from the system clock, and both lines are open-drain. The block pulls a line low by asserting its output enable and releases it otherwise. A transfer that reads data ends with the received byte stored in the data register. A target that fails to acknowledge ends the transfer early with a STOP and raises the error flag.

Top module: `sbus_byte_master`

## Requirements
- R1: Register offsets are 0 = word address, 1 = data, 2 = launch (bits 7:1 target address, bit 0 = 1 for read, 0 for write) and 3 = control/status. All four read 00h after any of the three active-low resets (`por_n`, `glob_rst_n`, `link_rst_n`) is asserted.
- R2: A write to offset 2 while idle starts a transfer. Busy (offset 3 bit 5) reads 1 from the next clock until the transfer's STOP has completed, and 0 after that.
- R3: A write transfer with offset 3 bit 7 = 0 puts START, {address,0}, the word address, the data byte and STOP on the bus. Every byte goes MSB first and is followed by an acknowledge slot.
- R4: A read transfer with bit 7 = 0 puts START, {address,0}, the word address, a repeated START, {address,1}, one received byte answered by the master with NACK, and STOP on the bus. The received byte replaces the data register.
- R5: With bit 7 = 1 the word-address byte is left out. A write sends START, {address,0}, data, STOP. A read sends START, {address,1}, receives one byte with NACK, then STOP.
- R6: If any byte the master sends is not acknowledged, the master issues STOP next, sets the sticky error flag (offset 3 bit 2) and clears busy. Writing 1 to bit 2 clears the flag. Writing 0 leaves it unchanged.
- R7: A write to offset 2 while busy is ignored. The register keeps its value and no second transfer follows.
- R8: Offset 3 bit 4 follows the `ee_load_busy` input. Bit 6 always reads 0.
- R9: Offset 3 bit 3 takes the value of `ee_present` on the first clock after reset ends, and software can overwrite it.
- R10: SCL has a period of 4*DIV clocks. The master changes SDA only while SCL is low, except for the START and STOP edges. Both lines are released when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| glob_rst_n | input | 1 | Global reset, active low |
| link_rst_n | input | 1 | Link reset, active low |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ee_load_busy | input | 1 | Configuration download in progress |
| ee_present | input | 1 | Memory present, sampled after reset |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that no target stretches the clock and that no other master drives the bus. The SDA timing property covers only the master's own enable, so a target changing SDA while SCL is high is outside its scope. The bench's target model follows these assumptions. It drives SDA only after it has seen SCL fall, and it never holds SCL. Register writes in the bench are single-cycle strobes issued between clock edges, which matches the launch and error-clear properties.

// File: rtl/sbus_byte_master.sv
module sbus_byte_master #(
  parameter int unsigned DIV = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       glob_rst_n,
  input  logic       link_rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ee_load_busy,
  input  logic       ee_present,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CLAST = CW'(DIV - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_SADR, ST_WORD, ST_RSTA,
    ST_SADR2, ST_WDAT, ST_RDAT, ST_STOP
  } st_t;

  st_t st, after;
  logic rst;
  logic [7:0] waddr_q, data_q, sac_q, sh, rx, ld;
  logic prot_q, det_q, err_q, first_q, miss;
  logic [CW-1:0] cnt;
  logic [1:0] q;
  logic [3:0] bitn;
  logic busy, in_ss, in_stop, is_byte, rd_byte, tick, seg_end, abort, launch, wr3;

  assign rst     = !(por_n && glob_rst_n && link_rst_n);
  assign busy    = (st != ST_IDLE);
  assign in_stop = (st == ST_STOP);
  assign in_ss   = (st == ST_START) || (st == ST_RSTA) || in_stop;
  assign is_byte = (st == ST_SADR) || (st == ST_WORD) || (st == ST_SADR2) ||
                   (st == ST_WDAT) || (st == ST_RDAT);
  assign rd_byte = (st == ST_RDAT);
  assign tick    = (cnt == CLAST);
  assign seg_end = busy && tick && (q == 2'd3) && (!is_byte || bitn == 4'd8);
  assign abort   = seg_end && is_byte && !rd_byte && miss;
  assign launch  = reg_wr && (reg_addr == 2'd2) && !busy;
  assign wr3     = reg_wr && (reg_addr == 2'd3);

  always_comb begin
    case (st)
      ST_START: after = ST_SADR;
      ST_SADR:  after = prot_q ? (sac_q[0] ? ST_RDAT : ST_WDAT) : ST_WORD;
      ST_WORD:  after = sac_q[0] ? ST_RSTA : ST_WDAT;
      ST_RSTA:  after = ST_SADR2;
      ST_SADR2: after = ST_RDAT;
      default:  after = ST_STOP;
    endcase
    case (after)
      ST_SADR:  ld = {sac_q[7:1], sac_q[0] & prot_q};
      ST_WORD:  ld = waddr_q;
      ST_SADR2: ld = {sac_q[7:1], 1'b1};
      ST_WDAT:  ld = data_q;
      default:  ld = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; q <= 2'd0; bitn <= 4'd0;
      sh <= 8'h00; rx <= 8'h00; miss <= 1'b0; sac_q <= 8'h00;
    end else if (launch) begin
      sac_q <= reg_wdata;
      st <= ST_START; cnt <= '0; q <= 2'd0; bitn <= 4'd0;
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        q <= q + 2'd1;
        if (is_byte && q == 2'd2) begin
          if (bitn == 4'd8) miss <= sda_in;
          else rx <= {rx[6:0], sda_in};
        end
        if (q == 2'd3) begin
          if (seg_end) begin
            bitn <= 4'd0;
            if (in_stop) st <= ST_IDLE;
            else if (abort) st <= ST_STOP;
            else begin
              st <= after;
              sh <= ld;
            end
          end else if (is_byte) begin
            bitn <= bitn + 4'd1;
            sh <= {sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr_q <= 8'h00; data_q <= 8'h00; prot_q <= 1'b0;
      det_q <= 1'b0; err_q <= 1'b0; first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      if (reg_wr && reg_addr == 2'd0) waddr_q <= reg_wdata;
      if (seg_end && rd_byte) data_q <= rx;
      else if (reg_wr && reg_addr == 2'd1) data_q <= reg_wdata;
      if (wr3) begin
        prot_q <= reg_wdata[7];
        det_q  <= reg_wdata[3];
      end else if (first_q) det_q <= ee_present;
      if (abort) err_q <= 1'b1;
      else if (wr3 && reg_wdata[2]) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = waddr_q;
      2'd1:    reg_rdata = data_q;
      2'd2:    reg_rdata = sac_q;
      default: reg_rdata = {prot_q, 1'b0, busy, ee_load_busy, det_q, err_q, 2'b00};
    endcase
  end

  assign scl_oe = busy && ((q == 2'd0) || (q == 2'd3 && !in_stop));
  assign sda_oe = ((st == ST_START || st == ST_RSTA) && q[1]) ||
                  (in_stop && !q[1]) ||
                  (is_byte && bitn != 4'd8 && !rd_byte && !sh[7]);

endmodule

// File: rtl/sbus_byte_master_chk.sv
module sbus_byte_master_chk (
  input logic       clk,
  input logic       por_n,
  input logic       glob_rst_n,
  input logic       link_rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       err,
  input logic       in_ss,
  input logic       in_stop,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] sac
);
  logic rst;
  assign rst = !(por_n && glob_rst_n && link_rst_n);

  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && !busy) |=> busy);

  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && busy) |=> $stable(sac));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !(reg_wr && reg_addr == 2'd3 && reg_wdata[2])) |=> err);

  a_r6_abort_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> in_stop);

  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> $past(in_ss));
endmodule

bind sbus_byte_master sbus_byte_master_chk u_chk (
  .clk(clk), .por_n(por_n), .glob_rst_n(glob_rst_n), .link_rst_n(link_rst_n),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(busy), .err(err_q), .in_ss(in_ss), .in_stop(in_stop),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .sac(sac_q)
);

// File: tb/sbus_byte_master_tb.sv
module sbus_byte_master_tb;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h50;
  localparam int T_START = 1000;
  localparam int T_STOP  = 1001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, glob_rst_n = 1'b1, link_rst_n = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic ee_load_busy = 1'b0, ee_present = 1'b0;
  logic scl_oe, sda_oe;
  logic s_oe = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_oe);

  sbus_byte_master #(.DIV(DIV)) u_dut (
    .clk(clk), .por_n(por_n), .glob_rst_n(glob_rst_n), .link_rst_n(link_rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_load_busy(ee_load_busy), .ee_present(ee_present), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // monitor: bus target model, pops expected tokens
  logic [7:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 8'h00;
  logic psc = 1'b1, psd = 1'b1, first = 1'b0, addressed = 1'b0, rd_mode = 1'b0;
  logic pend_rd = 1'b0, ptr_next = 1'b0, mnack = 1'b0, per_done = 1'b0;
  logic [7:0] sr = 8'h00, tx = 8'h00;
  logic [3:0] ptr = 4'd0;
  int bc = 0, last_rise = 0;

  task automatic tok(int code);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R3 R4 R5 R7 unexpected bus token actual=%0d expected=none", code);
    end else chk("R3 R4 R5 R6 bus token", code, exp_q.pop_front());
  endtask

  always @(negedge clk) begin
    if (scl_w && psc && psd && !sda_w) begin
      tok(T_START); bc = 0; first = 1; rd_mode = 0; pend_rd = 0; s_oe = 0; ptr_next = 1;
    end else if (scl_w && psc && !psd && sda_w) begin
      tok(T_STOP); bc = 0; rd_mode = 0; first = 0; addressed = 0; s_oe = 0;
    end else if (scl_w && !psc) begin
      if (!rd_mode && bc < 8) sr = {sr[6:0], sda_w};
      if (rd_mode && bc == 8) mnack = sda_w;
      if (bc >= 1 && bc <= 7 && !per_done) begin
        chk("R10 SCL period", cyc - last_rise, 4 * DIV);
        per_done = 1;
      end
      last_rise = cyc;
      bc++;
    end else if (!scl_w && psc) begin
      if (bc == 8) begin
        if (!rd_mode) begin
          tok(int'(sr));
          if (first) begin
            addressed = (sr[7:1] == SLV);
            pend_rd = addressed && sr[0];
            first = 0;
          end else if (addressed) begin
            if (ptr_next) begin ptr = sr[3:0]; ptr_next = 0; end
            else begin mem[ptr] = sr; ptr++; end
          end
          s_oe = addressed;
        end else s_oe = 0;
      end else if (bc == 9) begin
        bc = 0;
        s_oe = 0;
        if (rd_mode) begin
          tok((mnack ? 2000 : 3000) + int'(tx));
          ptr++;
          rd_mode = 0;
        end
        if (pend_rd) begin
          pend_rd = 0; rd_mode = 1; tx = mem[ptr]; s_oe = !tx[7];
        end
      end else if (rd_mode && bc >= 1 && bc <= 7) s_oe = !tx[7 - bc];
    end
    psc = scl_w; psd = sda_w;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [7:0] v);
    int n = 0;
    do begin @(negedge clk); rd(2'd3, v); n++; end while (v[5] && n < 20000);
  endtask

  // driver: pushes expected tokens, then launches the transfer
  task automatic run(input logic prot, input logic [6:0] a, input logic rw,
                     input logic [7:0] wa, input logic [7:0] dt, input logic [7:0] rexp,
                     input logic ign);
    logic [7:0] v;
    exp_q.push_back(T_START);
    exp_q.push_back(int'({a, rw & prot}));
    if (a != SLV) exp_q.push_back(T_STOP);
    else begin
      if (!prot) exp_q.push_back(int'(wa));
      if (rw) begin
        if (!prot) begin exp_q.push_back(T_START); exp_q.push_back(int'({a, 1'b1})); end
        exp_q.push_back(2000 + int'(rexp));
      end else exp_q.push_back(int'(dt));
      exp_q.push_back(T_STOP);
    end
    wr(2'd0, wa); wr(2'd1, dt); wr(2'd3, {prot, 7'b0});
    wr(2'd2, {a, rw});
    rd(2'd3, v); chk("R2 busy after launch", v[5], 1);
    if (ign) begin
      wr(2'd2, 8'h45);
      rd(2'd2, v); chk("R7 launch register unchanged while busy", v, {a, rw});
    end
    wait_idle(v);
    chk("R2 busy clear after STOP", v[5], 0);
    chk("R3 R4 R5 R7 all expected tokens seen", exp_q.size(), 0);
    chk("R10 lines released when idle", {scl_w, sda_w}, 2'b11);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) por_n = 0; else if (which == 1) glob_rst_n = 0; else link_rst_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1; glob_rst_n = 1; link_rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    por_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 reset value", v, 0);
    end

    run(1'b0, SLV, 1'b0, 8'h05, 8'hA7, 8'h00, 1'b0);          // R3
    rd(2'd3, v); chk("R6 no error after acked write", v[2], 0);
    run(1'b0, SLV, 1'b1, 8'h05, 8'h00, 8'hA7, 1'b0);          // R4
    rd(2'd1, v); chk("R4 received byte in data register", v, 8'hA7);
    run(1'b0, SLV, 1'b0, 8'h0C, 8'h5A, 8'h00, 1'b0);
    run(1'b1, SLV, 1'b0, 8'h00, 8'h0C, 8'h00, 1'b0);          // R5 write
    run(1'b1, SLV, 1'b1, 8'h00, 8'h00, 8'h5A, 1'b0);          // R5 read
    rd(2'd1, v); chk("R5 short-mode read data", v, 8'h5A);

    run(1'b0, 7'h33, 1'b0, 8'h01, 8'h02, 8'h00, 1'b0);        // R6
    rd(2'd3, v); chk("R6 error set on missing ack", v[2], 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R6 writing 0 keeps error", v[2], 1);
    wr(2'd3, 8'h04);
    rd(2'd3, v); chk("R6 writing 1 clears error", v[2], 0);
    run(1'b1, 7'h33, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
    rd(2'd3, v); chk("R6 error on short-mode read nack", v[2], 1);
    wr(2'd3, 8'h04);

    run(1'b0, SLV, 1'b0, 8'h03, 8'h11, 8'h00, 1'b1);          // R7

    ee_load_busy = 1;
    @(negedge clk); rd(2'd3, v); chk("R8 download flag follows input", v[4], 1);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R8 R9 control readback, bit6 zero", v, 8'h98);
    ee_load_busy = 0;
    @(negedge clk); rd(2'd3, v); chk("R8 download flag low", v[4], 0);

    ee_present = 1;
    pulse(1);
    rd(2'd3, v); chk("R9 detect after global reset", v, 8'h08);
    rd(2'd2, v); chk("R1 launch cleared by global reset", v, 0);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R9 detect writable by software", v[3], 0);
    ee_present = 0;

    wr(2'd1, 8'h55);
    pulse(2);
    rd(2'd1, v); chk("R1 data cleared by link reset", v, 0);
    wr(2'd0, 8'h66);
    pulse(0);
    rd(2'd0, v); chk("R1 word address cleared by power-on reset", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule